// File: doc/BRIEF.md
# Interrupt Enable, Mode and Summary Registers

This block holds the privileged interrupt-control state of a processor core: per-class interrupt enables, the current privilege mode, software interrupt requests and latched hardware interrupt requests. Software reaches it through a register-access port with an 8-bit function code, a write strobe, 64-bit write data and 64-bit read data. Reads are combinational on the function code. Writes take effect at the clock edge on which the strobe is sampled.

A summary word reports what is pending. Each request class is ANDed with its enable and placed at the bit position of that enable. Pending asynchronous traps come in from the process-context logic as a per-mode enable vector and a per-mode request vector. A trap for mode m is shown only when m is at or below the current mode. Hardware sources set sticky request flags, and software acknowledges them through a clear register. After every write that can change the interrupt picture, a one-cycle recheck pulse is raised so that downstream logic re-evaluates. Prioritisation and delivery are handled elsewhere.

Top module: `irq_ctl_regs`

## Requirements
- R1: After reset all enables, software requests and latched hardware requests are zero, the mode is 0, `recheck` is low, and reads of functions 0x0A, 0x0C and 0x0D return 0.
- R2: A write to function 0x0A loads the enable word from data bits 38:13 and leaves the mode unchanged. The layout is: trap enable at 13, software enables at 28:14, performance-counter enables at 30:29, corrected-read enable at 31, serial-line enable at 32, external enables at 38:33. Every other bit reads as 0.
- R3: A write to function 0x09 loads the mode from data bits 4:3 and leaves the enables unchanged.
- R4: A write to function 0x0B loads both the enables and the mode from the same data word. Reads of functions 0x08, 0x09, 0x0A and 0x0B all return the enables and the mode in their write positions.
- R5: A write to function 0x0C loads the software requests from data bits 28:14, and a read of 0x0C returns them at the same bits with every other bit 0.
- R6: A read of function 0x0D returns, at each enable bit position, the request of that class ANDed with its enable. The external requests are the live `ext_irq` levels at bits 38:33. Bit 13 reads as 0.
- R7: In the summary, the trap for mode m is set only when m ≤ mode, `trap_ena[m]`, `trap_req[m]` and the trap enable (bit 13) are all 1. Modes 0 and 1 appear at bits 4:3, and modes 2 and 3 at bits 10:9.
- R8: A high level on `pc_set[i]`, `cr_set` or `sl_set` at a clock edge sets the matching latched flag, which stays set after the input falls.
- R9: A write to function 0x0E clears the latched flags selected by ones in data bits 30:29 (performance counter), 31 (corrected read) and 32 (serial line). A set and a clear of the same flag in the same cycle leave the flag set.
- R10: `recheck` is high for exactly the one cycle after a write to function 0x09, 0x0A, 0x0B or 0x0C, and stays low after writes to any other function.
- R11: Reads of unassigned functions return 0. Writes to 0x08, 0x0D or an unassigned function change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_fn | input | 8 | Register function code |
| acc_we | input | 1 | Write strobe |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for `acc_fn` |
| trap_ena | input | 4 | Per-mode asynchronous-trap enable from context logic |
| trap_req | input | 4 | Per-mode asynchronous-trap request from context logic |
| ext_irq | input | 6 | External interrupt request levels |
| pc_set | input | 2 | Performance-counter interrupt set pulses |
| cr_set | input | 1 | Corrected-read-error interrupt set pulse |
| sl_set | input | 1 | Serial-line interrupt set pulse |
| cur_mode | output | 2 | Current privilege mode |
| recheck | output | 1 | One-cycle pulse after an interrupt-state write |

## Verification
The assertions assume that the access port is driven cleanly: `acc_fn`, `acc_we` and `acc_wdata` are stable around each rising edge and are never unknown out of reset. They also assume that the hardware set inputs are synchronous levels sampled once per edge. The bench meets these assumptions by changing every input only on the falling clock edge, holding each write strobe for exactly one rising edge and returning it low before the next access. Set/clear collisions are produced by putting a set input and a clear write into the same half-cycle window.

// File: rtl/irq_regs_pkg.sv
// Package: shared bit positions, function codes and the packed enable type
// for the interrupt-control register block. The enable struct is laid out
// so that its packed image matches data bits 38:13 exactly.
package irq_regs_pkg;

    localparam int DATA_W    = 64;
    localparam int FN_W      = 8;
    localparam int MODE_W    = 2;
    localparam int NUM_MODES = 1 << MODE_W;
    localparam int SW_W      = 15;
    localparam int PC_W      = 2;
    localparam int EXT_W     = 6;

    // Bit positions inside the data word
    localparam int POS_MODE  = 3;
    localparam int POS_AST   = 13;
    localparam int POS_SW    = POS_AST + 1;
    localparam int POS_PC    = POS_SW + SW_W;
    localparam int POS_CR    = POS_PC + PC_W;
    localparam int POS_SL    = POS_CR + 1;
    localparam int POS_EXT   = POS_SL + 1;
    localparam int ENA_W     = POS_EXT + EXT_W - POS_AST;
    localparam int POS_TRAP_LO = 3;
    localparam int POS_TRAP_HI = 9;
    localparam int TRAP_HALF   = NUM_MODES / 2;

    typedef logic [FN_W-1:0] fn_t;

    localparam fn_t FN_ALIAS = 8'h08;
    localparam fn_t FN_MODE  = 8'h09;
    localparam fn_t FN_ENA   = 8'h0A;
    localparam fn_t FN_BOTH  = 8'h0B;
    localparam fn_t FN_SWREQ = 8'h0C;
    localparam fn_t FN_SUM   = 8'h0D;
    localparam fn_t FN_CLR   = 8'h0E;

    typedef struct packed {
        logic [EXT_W-1:0] ext;
        logic             sl;
        logic             cr;
        logic [PC_W-1:0]  pc;
        logic [SW_W-1:0]  sw;
        logic             ast;
    } ena_t;

endpackage

// File: rtl/irq_ena_mode.sv
// Module: holds the interrupt enable word and the current privilege mode.
// Assumes the caller has decoded which of the two fields a write targets;
// both may be loaded in the same cycle from independent data slices.
module irq_ena_mode
    import irq_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mode,
    input  logic              ld_ena,
    input  logic [MODE_W-1:0] mode_in,
    input  ena_t              ena_in,
    output logic [MODE_W-1:0] mode_q,
    output ena_t              ena_q
);

    // Mode register: loaded only by a mode-carrying write
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (ld_mode) mode_q <= mode_in;
    end

    // Enable register: loaded only by an enable-carrying write
    always_ff @(posedge clk) begin
        if (!rst_n)      ena_q <= '0;
        else if (ld_ena) ena_q <= ena_in;
    end

endmodule

// File: rtl/irq_req_bank.sv
// Module: software request register and sticky hardware request flags.
// Assumes set inputs are synchronous; a set beats a clear in the same cycle.
module irq_req_bank
    import irq_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_sw,
    input  logic [SW_W-1:0]  sw_in,
    input  logic             do_clr,
    input  logic [PC_W-1:0]  clr_pc,
    input  logic             clr_cr,
    input  logic             clr_sl,
    input  logic [PC_W-1:0]  pc_set,
    input  logic             cr_set,
    input  logic             sl_set,
    output logic [SW_W-1:0]  sw_q,
    output logic [PC_W-1:0]  pc_q,
    output logic             cr_q,
    output logic             sl_q
);

    // Software request register: plain load
    always_ff @(posedge clk) begin
        if (!rst_n)     sw_q <= '0;
        else if (ld_sw) sw_q <= sw_in;
    end

    // One sticky flag per performance-counter source, set dominates clear
    for (genvar i = 0; i < PC_W; i++) begin : g_pc
        always_ff @(posedge clk) begin
            if (!rst_n)                  pc_q[i] <= 1'b0;
            else if (pc_set[i])          pc_q[i] <= 1'b1;
            else if (do_clr && clr_pc[i]) pc_q[i] <= 1'b0;
        end
    end

    // Corrected-read flag, set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n)                cr_q <= 1'b0;
        else if (cr_set)           cr_q <= 1'b1;
        else if (do_clr && clr_cr) cr_q <= 1'b0;
    end

    // Serial-line flag, set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n)                sl_q <= 1'b0;
        else if (sl_set)           sl_q <= 1'b1;
        else if (do_clr && clr_sl) sl_q <= 1'b0;
    end

endmodule

// File: rtl/irq_sum_read.sv
// Module: combinational summary word and read-data multiplexer.
// Assumes all register inputs are registered state; output is pure logic.
module irq_sum_read
    import irq_regs_pkg::*;
(
    input  fn_t                 fn,
    input  ena_t                ena,
    input  logic [MODE_W-1:0]   mode,
    input  logic [SW_W-1:0]     sw_req,
    input  logic [PC_W-1:0]     pc_req,
    input  logic                cr_req,
    input  logic                sl_req,
    input  logic [EXT_W-1:0]    ext_lvl,
    input  logic [NUM_MODES-1:0] trap_ena,
    input  logic [NUM_MODES-1:0] trap_req,
    output logic [DATA_W-1:0]   rdata
);

    logic [NUM_MODES-1:0] trap_pend;
    logic [DATA_W-1:0]    ctl_word;
    logic [DATA_W-1:0]    sw_word;
    logic [DATA_W-1:0]    sum_word;

    // Per-mode trap filter: visible only at or below the current mode
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_trap
        assign trap_pend[m] = (MODE_W'(m) <= mode) && trap_ena[m]
                              && trap_req[m] && ena.ast;
    end

    // Packed enable and mode image
    always_comb begin
        ctl_word = '0;
        ctl_word[POS_AST +: ENA_W]  = ena;
        ctl_word[POS_MODE +: MODE_W] = mode;
    end

    // Software request image
    always_comb begin
        sw_word = '0;
        sw_word[POS_SW +: SW_W] = sw_req;
    end

    // Summary: request AND enable per class, plus filtered traps
    always_comb begin
        sum_word = '0;
        sum_word[POS_SW +: SW_W]   = sw_req & ena.sw;
        sum_word[POS_PC +: PC_W]   = pc_req & ena.pc;
        sum_word[POS_CR]           = cr_req & ena.cr;
        sum_word[POS_SL]           = sl_req & ena.sl;
        sum_word[POS_EXT +: EXT_W] = ext_lvl & ena.ext;
        sum_word[POS_TRAP_LO +: TRAP_HALF] = trap_pend[TRAP_HALF-1:0];
        sum_word[POS_TRAP_HI +: TRAP_HALF] = trap_pend[NUM_MODES-1:TRAP_HALF];
    end

    // Read-data selection by function code
    always_comb begin
        unique case (fn)
            FN_ALIAS, FN_MODE, FN_ENA, FN_BOTH: rdata = ctl_word;
            FN_SWREQ:                           rdata = sw_word;
            FN_SUM:                             rdata = sum_word;
            default:                            rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctl_regs.sv
// Module: top of the interrupt-control register block. Decodes the access
// port into field loads, instantiates the state holders and the read path,
// and produces the recheck pulse. Assumes a single access per cycle.
module irq_ctl_regs
    import irq_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            acc_fn,
    input  logic                  acc_we,
    input  logic [63:0]           acc_wdata,
    output logic [63:0]           acc_rdata,
    input  logic [3:0]            trap_ena,
    input  logic [3:0]            trap_req,
    input  logic [5:0]            ext_irq,
    input  logic [1:0]            pc_set,
    input  logic                  cr_set,
    input  logic                  sl_set,
    output logic [1:0]            cur_mode,
    output logic                  recheck
);

    logic  ld_mode, ld_ena, ld_sw, do_clr, touch;
    ena_t  ena_q;
    logic [MODE_W-1:0] mode_q;
    logic [SW_W-1:0]   sw_req;
    logic [PC_W-1:0]   pc_req;
    logic              cr_req, sl_req;
    logic              recheck_q;
    logic              wdata_unused;

    // Write decode: which fields a write loads
    always_comb begin
        ld_mode = acc_we && (acc_fn == FN_MODE || acc_fn == FN_BOTH);
        ld_ena  = acc_we && (acc_fn == FN_ENA  || acc_fn == FN_BOTH);
        ld_sw   = acc_we && (acc_fn == FN_SWREQ);
        do_clr  = acc_we && (acc_fn == FN_CLR);
        touch   = ld_mode || ld_ena || ld_sw;
    end

    assign wdata_unused = ^{acc_wdata[DATA_W-1:POS_EXT+EXT_W],
                            acc_wdata[POS_AST-1:POS_MODE+MODE_W],
                            acc_wdata[POS_MODE-1:0]};

    irq_ena_mode u_ena (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_mode (ld_mode),
        .ld_ena  (ld_ena),
        .mode_in (acc_wdata[POS_MODE +: MODE_W]),
        .ena_in  (ena_t'(acc_wdata[POS_AST +: ENA_W])),
        .mode_q  (mode_q),
        .ena_q   (ena_q)
    );

    irq_req_bank u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_sw  (ld_sw),
        .sw_in  (acc_wdata[POS_SW +: SW_W]),
        .do_clr (do_clr),
        .clr_pc (acc_wdata[POS_PC +: PC_W]),
        .clr_cr (acc_wdata[POS_CR]),
        .clr_sl (acc_wdata[POS_SL]),
        .pc_set (pc_set),
        .cr_set (cr_set),
        .sl_set (sl_set),
        .sw_q   (sw_req),
        .pc_q   (pc_req),
        .cr_q   (cr_req),
        .sl_q   (sl_req)
    );

    irq_sum_read u_rd (
        .fn       (acc_fn),
        .ena      (ena_q),
        .mode     (mode_q),
        .sw_req   (sw_req),
        .pc_req   (pc_req),
        .cr_req   (cr_req),
        .sl_req   (sl_req),
        .ext_lvl  (ext_irq),
        .trap_ena (trap_ena),
        .trap_req (trap_req),
        .rdata    (acc_rdata)
    );

    // Recheck pulse: one cycle after any interrupt-state write
    always_ff @(posedge clk) begin
        if (!rst_n) recheck_q <= 1'b0;
        else        recheck_q <= touch;
    end

    assign recheck  = recheck_q;
    assign cur_mode = mode_q;

endmodule

// File: rtl/irq_ctl_regs_chk.sv
// Checker: temporal properties of the interrupt-control register block,
// bound to every instance of the top module.
module irq_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  acc_fn,
    input logic        acc_we,
    input logic [63:0] acc_wdata,
    input logic [63:0] acc_rdata,
    input logic        cr_set,
    input logic        cr_req,
    input logic [1:0]  cur_mode,
    input logic        recheck
);

    // R10: a state write yields a recheck pulse next cycle
    p_recheck_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_fn >= 8'h09 && acc_fn <= 8'h0C) |=> recheck);

    // R10: no recheck without a preceding state write
    p_recheck_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && acc_fn >= 8'h09 && acc_fn <= 8'h0C) |=> !recheck);

    // R3: mode only changes after a mode-carrying write
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && (acc_fn == 8'h09 || acc_fn == 8'h0B)) |=> $stable(cur_mode));

    // R8: a set input latches its flag
    p_cr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_set |=> cr_req);

    // R9: a clear without a concurrent set drops the flag
    p_cr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_fn == 8'h0E && acc_wdata[31] && !cr_set) |=> !cr_req);

    // R7: in mode 0 no trap above mode 0 is reported
    p_trap_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fn == 8'h0D && cur_mode == 2'd0) |-> (acc_rdata[4] == 1'b0 && acc_rdata[10:9] == 2'b00));

endmodule

bind irq_ctl_regs irq_ctl_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fn    (acc_fn),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .cr_set    (cr_set),
    .cr_req    (cr_req),
    .cur_mode  (cur_mode),
    .recheck   (recheck)
);

// File: tb/test_irq_ctl_regs.sv
`timescale 1ns/1ps
module test_irq_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_fn = '0;
    logic        acc_we = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic [3:0]  trap_ena = '0;
    logic [3:0]  trap_req = '0;
    logic [5:0]  ext_irq = '0;
    logic [1:0]  pc_set = '0;
    logic        cr_set = 1'b0;
    logic        sl_set = 1'b0;
    logic [1:0]  cur_mode;
    logic        recheck;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] ENA_MASK  = ((64'd1 << 39) - 1) & ~((64'd1 << 13) - 1);
    localparam logic [63:0] MODE_MASK = 64'h18;
    localparam logic [63:0] SW_MASK   = ((64'd1 << 29) - 1) & ~((64'd1 << 14) - 1);

    always #2.5 clk = ~clk;

    irq_ctl_regs i_irq_ctl_regs (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read a function at a falling edge
    task automatic rd(input logic [7:0] fn, output logic [63:0] v);
        @(negedge clk);
        acc_fn = fn;
        #1 v = acc_rdata;
    endtask

    // One write; checks the recheck pulse that follows (R10)
    task automatic wr(input logic [7:0] fn, input logic [63:0] d);
        logic exp_rc;
        @(negedge clk);
        acc_fn = fn; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
        exp_rc = (fn >= 8'h09 && fn <= 8'h0C);
        check("R10", {63'd0, recheck}, {63'd0, exp_rc});
        @(negedge clk);
        check("R10", {63'd0, recheck}, 64'd0);
    endtask

    function automatic logic [63:0] trap_exp(logic [1:0] m, logic [3:0] en, logic [3:0] rq, bit ast);
        logic [63:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (k <= m && en[k] && rq[k] && ast)
                r[(k < 2) ? 3 + k : 9 + k - 2] = 1'b1;
        return r;
    endfunction

    task automatic t_reset();
        logic [63:0] v;
        rd(8'h0A, v); check("R1", v, 64'd0);
        rd(8'h0C, v); check("R1", v, 64'd0);
        rd(8'h0D, v); check("R1", v, 64'd0);
        check("R1", {62'd0, cur_mode}, 64'd0);
        check("R1", {63'd0, recheck}, 64'd0);
    endtask

    task automatic t_enable_only();
        logic [63:0] v;
        wr(8'h09, 64'h10);
        wr(8'h0A, '1);
        rd(8'h0A, v); check("R2", v, ENA_MASK | 64'h10);
        wr(8'h0A, 64'h0000_0042_0000_2000);
        rd(8'h0A, v); check("R2", v, 64'h0000_0042_0000_2010);
    endtask

    task automatic t_mode_only();
        logic [63:0] v;
        wr(8'h09, '1);
        rd(8'h09, v); check("R3", v, 64'h0000_0042_0000_2018);
        check("R3", {62'd0, cur_mode}, 64'd3);
    endtask

    task automatic t_both();
        logic [63:0] v;
        logic [63:0] p = 64'h1234_0055_AAAA_5AF0;
        logic [63:0] e = (p & ENA_MASK) | (p & MODE_MASK);
        wr(8'h0B, p);
        for (int f = 8; f <= 11; f++) begin
            rd(8'(f), v); check("R4", v, e);
        end
    endtask

    task automatic t_swreq();
        logic [63:0] v;
        wr(8'h0C, '1);
        rd(8'h0C, v); check("R5", v, SW_MASK);
        wr(8'h0C, 64'h0000_0000_0555_4000);
        rd(8'h0C, v); check("R5", v, 64'h0000_0000_0555_4000);
    endtask

    task automatic t_summary();
        logic [63:0] v;
        wr(8'h0A, '1);
        wr(8'h0C, '1);
        ext_irq = 6'b101001;
        rd(8'h0D, v); check("R6", v, SW_MASK | (64'(6'b101001) << 33));
        wr(8'h0A, 64'h0000_0002_0000_0000 | (64'h3 << 14));
        rd(8'h0D, v); check("R6", v, (64'd1 << 33) | (64'h3 << 14));
        ext_irq = 6'b000000;
        rd(8'h0D, v); check("R6", v, 64'h3 << 14);
    endtask

    task automatic t_trap();
        logic [63:0] v;
        wr(8'h0C, 64'd0);
        wr(8'h0A, 64'h2000);
        trap_ena = 4'hF; trap_req = 4'hF;
        for (int m = 0; m < 4; m++) begin
            wr(8'h09, 64'(m) << 3);
            rd(8'h0D, v); check("R7", v, trap_exp(2'(m), 4'hF, 4'hF, 1'b1));
        end
        trap_req = 4'b1010;
        rd(8'h0D, v); check("R7", v, 64'h0000_0000_0000_0410);
        trap_ena = 4'b0111; trap_req = 4'hF;
        rd(8'h0D, v); check("R7", v, trap_exp(2'd3, 4'b0111, 4'hF, 1'b1));
        wr(8'h0A, 64'd0);
        rd(8'h0D, v); check("R7", v, 64'd0);
        trap_ena = 4'h0; trap_req = 4'h0;
    endtask

    task automatic t_hwset();
        logic [63:0] v;
        wr(8'h0A, '1);
        @(negedge clk); pc_set = 2'b10; cr_set = 1'b1;
        @(negedge clk); pc_set = 2'b00; cr_set = 1'b0;
        rd(8'h0D, v); check("R8", v, (64'd1 << 30) | (64'd1 << 31));
        repeat (3) @(negedge clk);
        rd(8'h0D, v); check("R8", v, (64'd1 << 30) | (64'd1 << 31));
    endtask

    task automatic t_clear();
        logic [63:0] v;
        wr(8'h0E, 64'd1 << 31);
        rd(8'h0D, v); check("R9", v, 64'd1 << 30);
        // set and clear of the serial-line flag in one cycle
        @(negedge clk);
        acc_fn = 8'h0E; acc_wdata = 64'd1 << 32; acc_we = 1'b1; sl_set = 1'b1;
        @(negedge clk);
        acc_we = 1'b0; sl_set = 1'b0;
        rd(8'h0D, v); check("R9", v, (64'd1 << 30) | (64'd1 << 32));
        wr(8'h0E, '1);
        rd(8'h0D, v); check("R9", v, 64'd0);
    endtask

    task automatic t_ignore();
        logic [63:0] v;
        rd(8'h07, v); check("R11", v, 64'd0);
        rd(8'h10, v); check("R11", v, 64'd0);
        wr(8'h0C, 64'h0000_0000_0000_C000);
        wr(8'h08, 64'd0);
        wr(8'h0D, 64'd0);
        wr(8'h20, 64'd0);
        rd(8'h0A, v); check("R11", v, ENA_MASK | (64'(cur_mode) << 3));
        rd(8'h0C, v); check("R11", v, 64'h0000_0000_0000_C000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_only();
        t_mode_only();
        t_both();
        t_swreq();
        t_summary();
        t_trap();
        t_hwset();
        t_clear();
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule